// File: doc/BRIEF.md
# Communication Board Local Control Registers

This block is the register file that the on-board processor of a network communication board sees on its local bus. It decodes two 256-byte windows, a control window and an I/O window, on a 16-bit data bus with a two-bit byte-lane write mask. From those writes it produces four things. It selects which half of the shared communication RAM is visible, by driving the upper RAM address bit. It keeps the pending level-2 and level-5 interrupt flags, and the processor clears each one by writing to an acknowledge offset. It turns receive and transmit on and off when a special low-byte value is written. It also holds the local processor in reset or lets it run.

The network side raises the level-2 and level-5 interrupt requests with one-cycle pulses. The level-6 request follows the receive enable register directly. Writes take effect at the clock edge on which `bus_valid` and `bus_we` are high. Read data is combinational from the current register state while `bus_valid` is high and `bus_we` is low. Reads have no side effects. The block has no state machine: every register is a plain flag or word with a next-value rule.

Top module: `comm_ctrl_regs`

## Requirements
- R1: A write to control offset 0x00 stores all 16 data bits in the bank register. Bit 0 of that register drives `ram_addr_hi`, which is the 0x10000 address bit of the shared RAM.
- R2: A read of control offset 0x00 returns the stored bank register.
- R3: A write of any data to control offset 0x40 clears the pending level-5 interrupt. A write of any data to control offset 0xA0 clears the pending level-2 interrupt.
- R4: Writes to control offsets 0x80, 0xC0 and 0xE0 change no output and no readable register. A read of any control offset other than 0x00 returns 0.
- R5: A write to I/O offset 0x16 whose low byte is 0x8C sets `rx_enable` and `irq_lvl6`. A write there with any other low byte clears both.
- R6: A write to I/O offset 0x1C whose low byte is 0x8C sets `tx_enable`. A write there with any other low byte, 0x00 included, clears it.
- R7: The status words at I/O offsets 0x88 and 0x8A can be written and read back. Mask bit 0 enables bits 7:0 and mask bit 1 enables bits 15:8. Lanes whose mask bit is clear keep their old value.
- R8: A write to I/O offset 0xC0 with nonzero data sets `cpu_run` to 1, which releases the local processor from reset. A write there with zero data sets it to 0.
- R9: Reads of I/O offsets 0x10 (receive result) and 0x18 (transmit result) return 5. Reads of any other I/O offset that is not a status word return 0.
- R10: Reset clears every register. After reset `ram_addr_hi`, `rx_enable`, `tx_enable`, `cpu_run` and all three interrupt outputs are 0.
- R11: A pending level-2 or level-5 interrupt stays asserted until its acknowledge write. When a set pulse and an acknowledge land in the same cycle, the interrupt ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_io | input | 1 | 0 = control window, 1 = I/O window |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte-lane write mask (bit 0 = low byte) |
| bus_rdata | output | 16 | Read data |
| irq2_set | input | 1 | Pulse that raises the level-2 interrupt |
| irq5_set | input | 1 | Pulse that raises the level-5 interrupt |
| ram_addr_hi | output | 1 | Upper address bit for the shared RAM |
| rx_enable | output | 1 | Receive enabled |
| tx_enable | output | 1 | Transmit enabled |
| cpu_run | output | 1 | 1 = local processor released from reset |
| irq_lvl2 | output | 1 | Level-2 interrupt request |
| irq_lvl5 | output | 1 | Level-5 interrupt request |
| irq_lvl6 | output | 1 | Level-6 interrupt request |

## Verification
The hardest case to reach from the ports is a set pulse and an acknowledge write landing in the same cycle. The interrupt must still be pending afterwards. The bench drives the acknowledge write and the set pulse on the same falling edge and then checks the interrupt output. The byte-lane retention of the status words is also only visible through the bus. The bench fills a word, rewrites it one lane at a time, and reads it back after each write.

// File: rtl/commreg_pkg.sv
package commreg_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int LANES  = DATA_W / 8;

    // control window offsets
    localparam logic [ADDR_W-1:0] C_BANK  = 8'h00;
    localparam logic [ADDR_W-1:0] C_ACK5  = 8'h40;
    localparam logic [ADDR_W-1:0] C_LAMP  = 8'h80;
    localparam logic [ADDR_W-1:0] C_ACK2  = 8'hA0;
    localparam logic [ADDR_W-1:0] C_NODE  = 8'hC0;
    localparam logic [ADDR_W-1:0] C_MISC  = 8'hE0;

    // I/O window offsets
    localparam logic [ADDR_W-1:0] I_RXRES = 8'h10;
    localparam logic [ADDR_W-1:0] I_RXGO  = 8'h16;
    localparam logic [ADDR_W-1:0] I_TXRES = 8'h18;
    localparam logic [ADDR_W-1:0] I_TXGO  = 8'h1C;
    localparam logic [ADDR_W-1:0] I_STAT0 = 8'h88;
    localparam logic [ADDR_W-1:0] I_STAT1 = 8'h8A;
    localparam logic [ADDR_W-1:0] I_RUN   = 8'hC0;

    localparam logic [7:0]        GO_CODE = 8'h8C;
    localparam logic [DATA_W-1:0] RESULT  = 16'd5;

    // write strobes out of the decoder
    typedef struct packed {
        logic       bank;
        logic       ack5;
        logic       ack2;
        logic       rxgo;
        logic       txgo;
        logic       run;
        logic [1:0] stat;
    } wr_strobe_t;

    // read source selection
    typedef enum logic [2:0] {
        RD_ZERO,
        RD_BANK,
        RD_STAT0,
        RD_STAT1,
        RD_RESULT
    } rd_sel_t;

endpackage

// File: rtl/commreg_decode.sv
module commreg_decode
    import commreg_pkg::*;
(
    input  logic              valid,
    input  logic              we,
    input  logic              io,
    input  logic [ADDR_W-1:0] addr,
    output wr_strobe_t        wr,
    output rd_sel_t           rsel
);

    always_comb begin
        wr   = '0;
        rsel = RD_ZERO;
        if (valid && we && !io) begin
            case (addr)
                C_BANK:  wr.bank = 1'b1;
                C_ACK5:  wr.ack5 = 1'b1;
                C_ACK2:  wr.ack2 = 1'b1;
                default: ;                 // lamp, node, misc and others: accepted, no effect
            endcase
        end else if (valid && we && io) begin
            case (addr)
                I_RXGO:  wr.rxgo    = 1'b1;
                I_TXGO:  wr.txgo    = 1'b1;
                I_STAT0: wr.stat[0] = 1'b1;
                I_STAT1: wr.stat[1] = 1'b1;
                I_RUN:   wr.run     = 1'b1;
                default: ;
            endcase
        end else if (valid && !we && !io) begin
            rsel = (addr == C_BANK) ? RD_BANK : RD_ZERO;
        end else if (valid && !we && io) begin
            case (addr)
                I_RXRES, I_TXRES: rsel = RD_RESULT;
                I_STAT0:          rsel = RD_STAT0;
                I_STAT1:          rsel = RD_STAT1;
                default:          rsel = RD_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/commreg_irq.sv
module commreg_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] ack,
    output logic [N-1:0] pend
);

    for (genvar i = 0; i < N; i++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[i] <= 1'b0;
            else if (set[i])
                pend[i] <= 1'b1;      // set wins over acknowledge
            else if (ack[i])
                pend[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/commreg_status.sv
module commreg_status #(
    parameter int WORDS  = 2,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WORDS-1:0]              wr,
    input  logic [DATA_W/8-1:0]           be,
    input  logic [DATA_W-1:0]             wdata,
    output logic [WORDS-1:0][DATA_W-1:0]  q
);

    localparam int LANES = DATA_W / 8;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[w][l*8 +: 8] <= 8'h00;
                else if (wr[w] && be[l])
                    q[w][l*8 +: 8] <= wdata[l*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/comm_ctrl_regs.sv
module comm_ctrl_regs
    import commreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic              bus_io,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [LANES-1:0]  bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq2_set,
    input  logic              irq5_set,
    output logic              ram_addr_hi,
    output logic              rx_enable,
    output logic              tx_enable,
    output logic              cpu_run,
    output logic              irq_lvl2,
    output logic              irq_lvl5,
    output logic              irq_lvl6
);

    wr_strobe_t              wr;
    rd_sel_t                 rsel;
    logic [DATA_W-1:0]       bank_q;
    logic                    rx_q, tx_q, run_q;
    logic [1:0]              pend;
    logic [1:0][DATA_W-1:0]  stat_q;

    commreg_decode u_dec (
        .valid (bus_valid),
        .we    (bus_we),
        .io    (bus_io),
        .addr  (bus_addr),
        .wr    (wr),
        .rsel  (rsel)
    );

    commreg_irq #(.N(2)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({irq5_set, irq2_set}),
        .ack   ({wr.ack5, wr.ack2}),
        .pend  (pend)
    );

    commreg_status #(.WORDS(2), .DATA_W(DATA_W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr.stat),
        .be    (bus_be),
        .wdata (bus_wdata),
        .q     (stat_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            rx_q   <= 1'b0;
            tx_q   <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            if (wr.bank) bank_q <= bus_wdata;
            if (wr.rxgo) rx_q   <= (bus_wdata[7:0] == GO_CODE);
            if (wr.txgo) tx_q   <= (bus_wdata[7:0] == GO_CODE);
            if (wr.run)  run_q  <= (bus_wdata != '0);
        end
    end

    always_comb begin
        unique case (rsel)
            RD_BANK:   bus_rdata = bank_q;
            RD_STAT0:  bus_rdata = stat_q[0];
            RD_STAT1:  bus_rdata = stat_q[1];
            RD_RESULT: bus_rdata = RESULT;
            default:   bus_rdata = '0;
        endcase
    end

    assign ram_addr_hi = bank_q[0];
    assign rx_enable   = rx_q;
    assign irq_lvl6    = rx_q;
    assign tx_enable   = tx_q;
    assign cpu_run     = run_q;
    assign irq_lvl2    = pend[0];
    assign irq_lvl5    = pend[1];

endmodule

// File: rtl/comm_ctrl_regs_chk.sv
module comm_ctrl_regs_chk
    import commreg_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_valid,
    input logic                     bus_we,
    input logic                     bus_io,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [LANES-1:0]         bus_be,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic                     irq2_set,
    input logic                     irq5_set,
    input logic                     ram_addr_hi,
    input logic                     rx_enable,
    input logic                     tx_enable,
    input logic                     cpu_run,
    input logic                     irq_lvl2,
    input logic                     irq_lvl5,
    input logic                     irq_lvl6,
    input logic [1:0][DATA_W-1:0]   stat_q
);

    logic cw, iw, ir;
    assign cw = bus_valid && bus_we && !bus_io;
    assign iw = bus_valid && bus_we && bus_io;
    assign ir = bus_valid && !bus_we && bus_io;

    a_r1_bank_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && bus_addr == C_BANK) |=> (ram_addr_hi == $past(bus_wdata[0])));

    a_r3_ack5_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && bus_addr == C_ACK5 && !irq5_set) |=> !irq_lvl5);

    a_r3_ack2_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && bus_addr == C_ACK2 && !irq2_set) |=> !irq_lvl2);

    a_r5_rx_go: assert property (@(posedge clk) disable iff (!rst_n)
        (iw && bus_addr == I_RXGO) |=> (irq_lvl6 == rx_enable) &&
            (rx_enable == ($past(bus_wdata[7:0]) == GO_CODE)));

    a_r6_tx_go: assert property (@(posedge clk) disable iff (!rst_n)
        (iw && bus_addr == I_TXGO) |=> (tx_enable == ($past(bus_wdata[7:0]) == GO_CODE)));

    a_r7_low_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
        (iw && bus_addr == I_STAT0 && bus_be == 2'b01) |=> $stable(stat_q[0][15:8]));

    a_r8_run_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (iw && bus_addr == I_RUN) |=> (cpu_run == ($past(bus_wdata) != 16'h0)));

    a_r9_result: assert property (@(posedge clk) disable iff (!rst_n)
        (ir && (bus_addr == I_RXRES || bus_addr == I_TXRES)) |-> (bus_rdata == RESULT));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (irq5_set || irq2_set) |=> ($past(irq5_set) -> irq_lvl5) && ($past(irq2_set) -> irq_lvl2));

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl5 && !(cw && bus_addr == C_ACK5)) |=> irq_lvl5);

endmodule

bind comm_ctrl_regs comm_ctrl_regs_chk u_chk (.*);

// File: tb/comm_ctrl_regs_bench.sv
module comm_ctrl_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_we, bus_io;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [1:0]  bus_be;
    logic [15:0] bus_rdata;
    logic        irq2_set, irq5_set;
    logic        ram_addr_hi, rx_enable, tx_enable, cpu_run;
    logic        irq_lvl2, irq_lvl5, irq_lvl6;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    comm_ctrl_regs u_comm_ctrl_regs (.*);

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic io, input logic [7:0] a, input logic [15:0] d,
                      input logic [1:0] be = 2'b11);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_io = io;
        bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic io, input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_io = io; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic pulse(input logic two, input logic five);
        @(negedge clk);
        irq2_set = two; irq5_set = five;
        @(negedge clk);
        irq2_set = 1'b0; irq5_set = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R10 ram_addr_hi", 16'(ram_addr_hi), 16'h0);
        check("R10 cpu_run", 16'(cpu_run), 16'h0);
        check("R10 irqs", {13'h0, irq_lvl2, irq_lvl5, irq_lvl6}, 16'h0);
        check("R10 rx/tx", {14'h0, rx_enable, tx_enable}, 16'h0);
        rd(1'b0, 8'h00, v); check("R10 bank", v, 16'h0);
    endtask

    task automatic t_bank();
        logic [15:0] v;
        wr(1'b0, 8'h00, 16'hA5C3);
        check("R1 bank hi set", 16'(ram_addr_hi), 16'h1);
        rd(1'b0, 8'h00, v); check("R2 bank read", v, 16'hA5C3);
        wr(1'b0, 8'h00, 16'h0002);
        check("R1 bank hi clear", 16'(ram_addr_hi), 16'h0);
        rd(1'b0, 8'h00, v); check("R2 bank read 2", v, 16'h0002);
        wr(1'b0, 8'h00, 16'h0001);
    endtask

    task automatic t_irq_ack();
        pulse(1'b1, 1'b1);
        check("R11 lvl2 raised", 16'(irq_lvl2), 16'h1);
        check("R11 lvl5 raised", 16'(irq_lvl5), 16'h1);
        repeat (3) @(negedge clk);
        check("R11 lvl5 sticky", 16'(irq_lvl5), 16'h1);
        wr(1'b0, 8'h40, 16'h0000);
        check("R3 ack5 clears", 16'(irq_lvl5), 16'h0);
        check("R3 ack5 leaves lvl2", 16'(irq_lvl2), 16'h1);
        wr(1'b0, 8'hA0, 16'h1234);
        check("R3 ack2 clears", 16'(irq_lvl2), 16'h0);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_io = 1'b0; bus_addr = 8'h40;
        bus_wdata = 16'h0; bus_be = 2'b11; irq5_set = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0; irq5_set = 1'b0;
        check("R11 set wins over ack", 16'(irq_lvl5), 16'h1);
        wr(1'b0, 8'h40, 16'h0);
        check("R11 later ack clears", 16'(irq_lvl5), 16'h0);
    endtask

    task automatic t_ignored();
        logic [15:0] v;
        pulse(1'b1, 1'b0);
        wr(1'b0, 8'h80, 16'hFFFF);
        wr(1'b0, 8'hC0, 16'h7FFF);
        wr(1'b0, 8'hE0, 16'hFFFF);
        rd(1'b0, 8'h00, v); check("R4 bank untouched", v, 16'h0001);
        check("R4 ram_addr_hi untouched", 16'(ram_addr_hi), 16'h1);
        check("R4 lvl2 untouched", 16'(irq_lvl2), 16'h1);
        check("R4 cpu_run untouched", 16'(cpu_run), 16'h0);
        rd(1'b0, 8'h80, v); check("R4 read 0x80", v, 16'h0);
        rd(1'b0, 8'hC0, v); check("R4 read 0xC0", v, 16'h0);
        wr(1'b0, 8'hA0, 16'h0);
    endtask

    task automatic t_rx_tx();
        wr(1'b1, 8'h16, 16'h008C);
        check("R5 rx on", 16'(rx_enable), 16'h1);
        check("R5 irq6 on", 16'(irq_lvl6), 16'h1);
        wr(1'b1, 8'h16, 16'h8C00);
        check("R5 other low byte clears rx", 16'(rx_enable), 16'h0);
        check("R5 irq6 off", 16'(irq_lvl6), 16'h0);
        wr(1'b1, 8'h1C, 16'h558C);
        check("R6 tx on", 16'(tx_enable), 16'h1);
        check("R6 tx leaves rx", 16'(rx_enable), 16'h0);
        wr(1'b1, 8'h1C, 16'h0000);
        check("R6 tx off", 16'(tx_enable), 16'h0);
    endtask

    task automatic t_status();
        logic [15:0] v;
        wr(1'b1, 8'h88, 16'h1234, 2'b11);
        wr(1'b1, 8'h8A, 16'hABCD, 2'b11);
        rd(1'b1, 8'h88, v); check("R7 stat0 full", v, 16'h1234);
        wr(1'b1, 8'h88, 16'hFFEE, 2'b01);
        rd(1'b1, 8'h88, v); check("R7 stat0 low lane", v, 16'h12EE);
        wr(1'b1, 8'h88, 16'h77FF, 2'b10);
        rd(1'b1, 8'h88, v); check("R7 stat0 high lane", v, 16'h77EE);
        wr(1'b1, 8'h8A, 16'h0000, 2'b00);
        rd(1'b1, 8'h8A, v); check("R7 stat1 no lane", v, 16'hABCD);
    endtask

    task automatic t_run_result();
        logic [15:0] v;
        wr(1'b1, 8'hC0, 16'h0100);
        check("R8 run released", 16'(cpu_run), 16'h1);
        wr(1'b1, 8'hC0, 16'h0000);
        check("R8 run held", 16'(cpu_run), 16'h0);
        rd(1'b1, 8'h10, v); check("R9 rx result", v, 16'd5);
        rd(1'b1, 8'h18, v); check("R9 tx result", v, 16'd5);
        rd(1'b1, 8'h16, v); check("R9 other io read", v, 16'h0);
    endtask

    initial begin
        rst_n = 1'b0; bus_valid = 1'b0; bus_we = 1'b0; bus_io = 1'b0;
        bus_addr = '0; bus_wdata = '0; bus_be = '0; irq2_set = 1'b0; irq5_set = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bank();
        t_irq_ack();
        t_set_wins();
        t_ignored();
        t_rx_tx();
        t_status();
        t_run_result();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule